// File: doc/BRIEF.md
# Oversampling Serial Frame Receiver

This block recovers asynchronous serial frames from a single input line that it observes sixteen times per bit period. An oversample enable pulse, produced by a baud generator outside the block, marks each observation instant. A falling edge on the idle line opens a candidate start bit. The candidate is accepted only when the middle observations of that bit agree that the line is low. Each later bit is then decided by a two-out-of-three vote of the middle observations of its own bit period. The data bits arrive least significant first and are collected in a shift register.

When a frame completes, the block pushes the word into a two-entry receive queue together with its frame-error and parity-error status. If a frame completes while both entries are occupied, the new frame is dropped and the newest stored word is tagged with an overrun. The consumer sees the oldest word and its status at the read position. A one-cycle read strobe releases that word. The data length and parity mode are configuration inputs that must be held stable while a frame is being received.

Top module: `ovs_uart_rx`

## Requirements
- R1: After reset, rx_done, err_frame, err_parity and err_overrun are 0 and rx_data is 0.
- R2: A frame starts only on a high-to-low change between two consecutive observations of an idle line. If two or more of observations 8, 9 and 10 (counted from 1 at the edge) are high, the candidate is dropped and no word is stored.
- R3: Each start, data, parity and stop bit takes the majority value of observations 8, 9 and 10 of its bit period, so a single disagreeing observation among the three does not change the result.
- R4: cfg_len selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Bits are received least significant first. rx_data is right-aligned, and its bits above the length read 0.
- R5: cfg_par selects the parity mode: 00 and 01 mean no parity bit, 10 means even and 11 means odd. With even parity the data bits plus the parity bit hold an even number of ones; with odd parity they hold an odd number. A mismatch sets the word's err_parity.
- R6: A frame whose first stop bit is decided low is still stored, with err_frame set. Only the first stop bit is examined.
- R7: The queue holds up to two words and delivers them in arrival order. rx_done is 1 whenever at least one unread word is held.
- R8: A frame that completes while both entries are held is discarded. The newest held word is then marked with err_overrun, and the word ahead of it is not marked.
- R9: err_frame, err_parity and err_overrun describe the word at the read position. All three read 0 while rx_done is 0.
- R10: A read strobe while the queue is empty has no effect on the next word received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| os_tick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| cfg_len | input | 2 | Data length code (0..3 give 5..8 bits) |
| cfg_par | input | 2 | Parity mode (00/01 none, 10 even, 11 odd) |
| rd_strobe | input | 1 | One-cycle pulse that releases the word at the read position |
| rx_data | output | 8 | Word at the read position, right-aligned |
| rx_done | output | 1 | High while any unread word is held |
| err_frame | output | 1 | First stop bit of the word at the read position was low |
| err_parity | output | 1 | Parity mismatch for the word at the read position |
| err_overrun | output | 1 | One or more frames after this word were lost |

## Verification
The bench builds the block with its defaults: sixteen observations per bit, a two-stage input synchronizer and a two-entry queue. With these values every data length is swept against every parity mode over a spread of data patterns, and half of those frames carry one inverted middle observation per bit. A two-entry queue is shallow enough that a three-frame burst with no reads reaches the overrun case. Separate frames cover a short start glitch, a corrupted parity bit, a low stop bit and a read on an empty queue.

// File: rtl/ovs_rx_pkg.sv
// Package: shared types and helpers for the oversampling serial receiver.
// Assumes a fixed maximum data width of eight bits.
package ovs_rx_pkg;

    localparam int unsigned DATA_W = 8;

    // Receive sequencer states
    typedef enum logic [2:0] {
        F_IDLE,
        F_START,
        F_DATA,
        F_PAR,
        F_STOP
    } fsm_e;

    // One stored word with its status
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ferr;
        logic              perr;
        logic              ovr;
    } rx_word_t;

    // Two-out-of-three majority
    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/ovs_rx_sync.sv
// Module: multi-stage synchronizer for the asynchronous serial input.
// Assumes the line idles high, so every stage resets to 1.
module ovs_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture flop
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= 1'b1;
                else        chain <= d;
            end
        end else begin : g_many
            // Shift the input through the chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/ovs_rx_framer.sv
// Module: start detection, per-bit majority decision, data assembly and
// parity/stop checking. Emits a one-cycle push with the finished word.
// Assumes os_tick pulses OSR times per bit and configuration is held
// stable while a frame is in progress.
module ovs_rx_framer
    import ovs_rx_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     os_tick,
    input  logic     rx_s,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par,
    output logic     push,
    output rx_word_t word
);

    localparam int unsigned CW = $clog2(OSR);
    localparam logic [CW-1:0] V0   = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] V1   = CW'(OSR / 2);
    localparam logic [CW-1:0] V2   = CW'(OSR / 2 + 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    fsm_e              state;
    logic [CW-1:0]     cnt;
    logic              prev_q;
    logic [1:0]        votes;
    logic [2:0]        bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              maj;
    logic [2:0]        last_idx;

    assign maj      = vote3({rx_s, votes});
    assign last_idx = 3'd4 + {1'b0, cfg_len};

    // Sequence a frame one observation at a time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= F_IDLE;
            cnt     <= '0;
            prev_q  <= 1'b1;
            votes   <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            push    <= 1'b0;
            word    <= '0;
        end else begin
            push <= 1'b0;
            if (os_tick) begin
                prev_q <= rx_s;
                case (state)
                    F_IDLE: begin
                        if (prev_q && !rx_s) begin
                            state <= F_START;
                            cnt   <= CW'(1);
                        end
                    end
                    default: begin
                        if (cnt == V0 || cnt == V1) votes <= {votes[0], rx_s};
                        cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
                        if (cnt == V2) begin
                            case (state)
                                F_START: begin
                                    if (maj) begin
                                        state <= F_IDLE;
                                    end else begin
                                        state   <= F_DATA;
                                        bit_idx <= '0;
                                        shreg   <= '0;
                                    end
                                end
                                F_DATA: begin
                                    shreg[bit_idx] <= maj;
                                    if (bit_idx == last_idx)
                                        state <= cfg_par[1] ? F_PAR : F_STOP;
                                    else
                                        bit_idx <= bit_idx + 3'd1;
                                end
                                F_PAR: begin
                                    par_bit <= maj;
                                    state   <= F_STOP;
                                end
                                F_STOP: begin
                                    push      <= 1'b1;
                                    word.data <= shreg;
                                    word.ferr <= !maj;
                                    word.perr <= cfg_par[1] &&
                                                 (par_bit != ((^shreg) ^ cfg_par[0]));
                                    word.ovr  <= 1'b0;
                                    state     <= F_IDLE;
                                end
                                default: state <= F_IDLE;
                            endcase
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/ovs_rx_fifo.sv
// Module: shift-down receive queue. Entry 0 is always the read position.
// A push into a full queue with no read is dropped and marks the newest
// held entry with an overrun.
module ovs_rx_fifo
    import ovs_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  rx_word_t push_word,
    input  logic     pop,
    output rx_word_t head,
    output logic     nonempty,
    output logic [$clog2(DEPTH+1)-1:0] level
);

    localparam int unsigned LW = $clog2(DEPTH + 1);

    rx_word_t        slot [DEPTH];
    rx_word_t        up   [DEPTH];
    logic            pop_ok;
    logic            full;
    logic            accept;
    logic [LW-1:0]   wr_idx;

    assign pop_ok   = pop && (level != '0);
    assign full     = (level == LW'(DEPTH));
    assign accept   = push && (!full || pop_ok);
    assign wr_idx   = level - LW'(pop_ok);
    assign head     = slot[0];
    assign nonempty = (level != '0);

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_up
            if (i < DEPTH - 1) begin : g_mid
                assign up[i] = slot[i+1];
            end else begin : g_top
                assign up[i] = '0;
            end
        end
    endgenerate

    // Move, fill or mark each entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (accept && wr_idx == LW'(i))
                    slot[i] <= push_word;
                else if (pop_ok)
                    slot[i] <= up[i];
                else if (i == DEPTH - 1 && push && full)
                    slot[i].ovr <= 1'b1;
            end
        end
    end

    // Track the number of held words
    always_ff @(posedge clk) begin
        if (!rst_n) level <= '0;
        else        level <= level + LW'(accept) - LW'(pop_ok);
    end

endmodule

// File: rtl/ovs_uart_rx.sv
// Module: top of the oversampling serial receiver. Joins the input
// synchronizer, the frame sequencer and the receive queue, and presents
// the word at the read position with its status.
module ovs_uart_rx
    import ovs_rx_pkg::*;
#(
    parameter int unsigned OSR         = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DEPTH       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              os_tick,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_done,
    output logic              err_frame,
    output logic              err_parity,
    output logic              err_overrun
);

    logic                       rx_s;
    logic                       frm_push;
    rx_word_t                   frm_word;
    rx_word_t                   head;
    logic [$clog2(DEPTH+1)-1:0] fifo_level;

    ovs_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_line),
        .q     (rx_s)
    );

    ovs_rx_framer #(.OSR(OSR)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .os_tick (os_tick),
        .rx_s    (rx_s),
        .cfg_len (cfg_len),
        .cfg_par (cfg_par),
        .push    (frm_push),
        .word    (frm_word)
    );

    ovs_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (frm_push),
        .push_word (frm_word),
        .pop       (rd_strobe),
        .head      (head),
        .nonempty  (rx_done),
        .level     (fifo_level)
    );

    assign rx_data     = head.data;
    assign err_frame   = rx_done & head.ferr;
    assign err_parity  = rx_done & head.perr;
    assign err_overrun = rx_done & head.ovr;

endmodule

// File: rtl/ovs_uart_rx_chk.sv
// Module: property checker for the serial receiver, bound to the top.
// Observes the queue level and the push pulse from the sequencer.
module ovs_uart_rx_chk #(
    parameter int unsigned DEPTH = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rd_strobe,
    input logic [7:0]                 rx_data,
    input logic                       rx_done,
    input logic                       err_frame,
    input logic                       err_parity,
    input logic                       err_overrun,
    input logic                       frm_push,
    input logic [$clog2(DEPTH+1)-1:0] fifo_level
);

    assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= ($clog2(DEPTH+1))'(DEPTH));

    assert_done_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done == (fifo_level != '0));

    assert_hold_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rd_strobe) |=> (rx_done && $stable(rx_data)));

    assert_rise_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(frm_push));

    assert_empty_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |-> !(err_frame || err_parity || err_overrun));

    assert_fall_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_done) |-> $past(rd_strobe));

    assert_full_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_push && fifo_level == ($clog2(DEPTH+1))'(DEPTH) && !rd_strobe)
        |=> (fifo_level == ($clog2(DEPTH+1))'(DEPTH)));

    assert_push_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frm_push |=> !frm_push);

endmodule

bind ovs_uart_rx ovs_uart_rx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_strobe   (rd_strobe),
    .rx_data     (rx_data),
    .rx_done     (rx_done),
    .err_frame   (err_frame),
    .err_parity  (err_parity),
    .err_overrun (err_overrun),
    .frm_push    (frm_push),
    .fifo_level  (fifo_level)
);

// File: tb/ovs_uart_rx_tb.sv
module ovs_uart_rx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       os_tick = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_par = 2'd0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_done, err_frame, err_parity, err_overrun;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ovs_uart_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_done(rx_done), .err_frame(err_frame),
        .err_parity(err_parity), .err_overrun(err_overrun)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One observation period with the line at v
    task automatic sample(input logic v);
        @(negedge clk); rx_line = v; os_tick = 1'b0;
        @(negedge clk);
        @(negedge clk); os_tick = 1'b1;
        @(negedge clk); os_tick = 1'b0;
    endtask

    // One bit period; observation flip (0-based) is inverted when >= 0
    task automatic bit_out(input logic v, input int flip);
        for (int k = 0; k < 16; k++) sample((k == flip) ? ~v : v);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic [1:0] len,
                              input logic [1:0] par, input bit bad_par,
                              input bit bad_stop, input bit noisy);
        int n = 5 + len;
        logic p;
        bit_out(1'b0, noisy ? 8 : -1);
        for (int i = 0; i < n; i++) bit_out(d[i], noisy ? 7 + (i % 3) : -1);
        if (par[1]) begin
            p = (^d) ^ par[0] ^ bad_par;
            bit_out(p, noisy ? 9 : -1);
        end
        bit_out(~bad_stop, noisy ? 7 : -1);
        bit_out(1'b1, -1);
    endtask

    task automatic read_word;
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic expect_word(input string tag, input logic [7:0] d,
                               input bit fe, input bit pe, input bit ov);
        @(negedge clk);
        check_eq({tag, " rx_done"}, rx_done, 1);
        check_eq({tag, " data"}, rx_data, d);
        check_eq({tag, " err_frame"}, err_frame, fe);
        check_eq({tag, " err_parity"}, err_parity, pe);
        check_eq({tag, " err_overrun"}, err_overrun, ov);
        read_word();
    endtask

    task automatic expect_empty(input string tag);
        @(negedge clk);
        check_eq({tag, " rx_done"}, rx_done, 0);
        check_eq({tag, " flags"}, {err_frame, err_parity, err_overrun}, 0);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=expired expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [7:0] d, mask;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check_eq("R1 rx_done", rx_done, 0);
        check_eq("R1 rx_data", rx_data, 0);
        check_eq("R1 flags", {err_frame, err_parity, err_overrun}, 0);
        bit_out(1'b1, -1);

        // R4 R5 R3 sweep over lengths, parity modes and patterns
        for (int len = 0; len < 4; len++) begin
            for (int pm = 0; pm < 4; pm++) begin
                cfg_len = 2'(len);
                cfg_par = 2'(pm);
                mask = 8'((1 << (5 + len)) - 1);
                for (int v = 0; v < 6; v++) begin
                    d = 8'((v * 37 + len * 11 + pm * 5 + 13) & 8'hFF) & mask;
                    if (v == 4) d = mask;
                    if (v == 5) d = 8'h00;
                    send_frame(d, 2'(len), 2'(pm), 0, 0, v[0]);
                    expect_word($sformatf("R4 R5 R3 len=%0d par=%0d v=%0d", len, pm, v),
                                d, 0, 0, 0);
                    expect_empty("R7 after read");
                end
            end
        end

        cfg_len = 2'd3;

        // R5 parity mismatch, even and odd
        cfg_par = 2'b10;
        send_frame(8'h5A, 2'd3, 2'b10, 1, 0, 0);
        expect_word("R5 even mismatch", 8'h5A, 0, 1, 0);
        cfg_par = 2'b11;
        send_frame(8'hC3, 2'd3, 2'b11, 1, 0, 0);
        expect_word("R5 odd mismatch", 8'hC3, 0, 1, 0);
        cfg_par = 2'b00;

        // R6 low stop bit still stores the word
        send_frame(8'h96, 2'd3, 2'b00, 0, 1, 0);
        expect_word("R6 frame error", 8'h96, 1, 0, 0);
        expect_empty("R9 clean after error word");

        // R2 start glitch: low for observations 1..4 only
        for (int k = 0; k < 16; k++) sample(k < 4 ? 1'b0 : 1'b1);
        bit_out(1'b1, -1);
        expect_empty("R2 glitch rejected");

        // R10 read on empty queue
        read_word();
        expect_empty("R10 read on empty");
        send_frame(8'h3C, 2'd3, 2'b00, 0, 0, 0);
        expect_word("R10 next word intact", 8'h3C, 0, 0, 0);
        expect_empty("R10 single word only");

        // R7 two words in order, no overrun
        send_frame(8'h11, 2'd3, 2'b00, 0, 0, 0);
        send_frame(8'h22, 2'd3, 2'b00, 0, 0, 0);
        expect_word("R7 first", 8'h11, 0, 0, 0);
        expect_word("R7 second", 8'h22, 0, 0, 0);
        expect_empty("R7 drained");

        // R8 third frame lost, newest held word marked
        send_frame(8'hA1, 2'd3, 2'b00, 0, 0, 0);
        send_frame(8'hB2, 2'd3, 2'b00, 0, 0, 0);
        send_frame(8'hC3, 2'd3, 2'b00, 0, 0, 0);
        expect_word("R8 oldest unmarked", 8'hA1, 0, 0, 0);
        expect_word("R8 newest marked", 8'hB2, 0, 0, 1);
        expect_empty("R8 lost frame");

        // R9 error status follows its word through the queue
        send_frame(8'h0F, 2'd3, 2'b00, 0, 1, 0);
        send_frame(8'hF0, 2'd3, 2'b00, 0, 0, 0);
        expect_word("R9 errored head", 8'h0F, 1, 0, 0);
        expect_word("R9 clean follower", 8'hF0, 0, 0, 0);

        done = 1'b1;
        report();
        $finish;
    end

endmodule